// File: doc/BRIEF.md
# Presence-Detect Memory Target on a Two-Wire Serial Bus

This block is the small non-volatile identity store found on a memory card, seen from the system side through a two-wire serial bus (I2C). A host controller drives the clock line and shares the open-drain data line. The block oversamples both lines with the chip clock. It finds start and stop conditions, decodes a 7-bit target address with a read/write flag, and keeps a byte pointer into a 256-byte array. It shifts bytes in or out, most significant bit first, with an acknowledge slot on every ninth clock.

The lower half of the array holds fixed factory content, which is computed here from the byte address. The upper half is a register file that the host may rewrite. A write transaction that stored at least one data byte starts a programming interval after its stop condition. During that interval the block ignores its own address, and the host polls it by retrying the address until it is acknowledged. A random read is a write transaction that sends only a word address, followed by a repeated start in read mode.

Top module: `spd_i2c_target`

## Requirements
- R1: The block pulls the data line low only through `sda_oe`, and `sda_oe` changes only in the cycle after a falling clock edge is detected or after a start or stop condition. A falling data edge while the clock is high is a start; a rising one is a stop.
- R2: Clocked bits are ignored until a start condition has been seen. A stop condition releases the data line and returns the block to standby.
- R3: The target address is the 7-bit value binary 1010 followed by `addr_pins[2:0]`, and the eighth bit is 1 for read and 0 for write. A matching address is acknowledged by a low data line in the ninth clock. Any other address is not acknowledged.
- R4: In write mode the block acknowledges the word-address byte and every data byte after it.
- R5: In read mode the block sends the byte at the pointer, most significant bit first, then releases the line for the host's acknowledge. On a low acknowledge it sends the next byte. On a high one it leaves the line released until the next start or stop.
- R6: The pointer advances by one after each byte, read or written, and wraps from 255 to 0.
- R7: Bytes written at addresses 128 to 255 are stored and read back unchanged.
- R8: Writes to addresses 0 to 127 are acknowledged and discarded. The byte at address a in that half is the address with its two nibbles swapped, XOR 0x5A. For example, address 0x00 reads 0x5A and address 0x01 reads 0x4A.
- R9: A stop that ends a write with at least one data byte starts a busy interval of `WRITE_CYCLES` clocks. During that interval the block does not acknowledge its address. Afterwards it acknowledges its address again.
- R10: After reset the data line is released, the pointer is 0, and every byte of the upper half reads 0xFF.
- R11: A transaction that sends only a word address and then a repeated start does not start a busy interval, so the read that follows is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| addr_pins | input | 3 | Low three bits of the target address |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
A state machine that slips by one bit shows up at the host within one byte. The acknowledge appears in the wrong slot, or a read byte arrives shifted, by the ninth clock of the transaction where the slip happened. A wrong pointer or a write that lands in the fixed half shows up only on a later read, so the sequences read back across the 255-to-0 wrap and at the first bytes of the fixed half. A busy timer that is too short or never armed shows up at the first address retry after a stop, which comes back acknowledged when it should not be. A busy timer that never expires shows up when the retry after the interval is still refused.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int SPD_AW    = 8;
  localparam int SPD_BYTES = 1 << SPD_AW;
  localparam int SPD_HALF  = SPD_BYTES / 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADR, ST_WADR_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK, ST_RLOAD
  } spd_st_t;

  // Address byte matches 1010 + pins in its upper seven bits
  function automatic logic dev_match(input logic [7:0] b, input logic [2:0] pins);
    return b[7:1] == {4'b1010, pins};
  endfunction

  function automatic logic [SPD_AW-1:0] next_ptr(input logic [SPD_AW-1:0] p);
    return p + 1'b1;
  endfunction

  // Fixed content of the lower half
  function automatic logic [7:0] factory_byte(input logic [SPD_AW-1:0] a);
    return {a[3:0], a[7:4]} ^ 8'h5A;
  endfunction
endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/spd_store.sv
module spd_store
  import spd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SPD_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [7:0] user_q [SPD_HALF];
  logic       user_we;

  assign user_we = we & addr[SPD_AW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SPD_HALF; i++) user_q[i] <= 8'hFF;
    end else if (user_we) begin
      user_q[addr[SPD_AW-2:0]] <= wdata;
    end
  end

  assign rdata = addr[SPD_AW-1] ? user_q[addr[SPD_AW-2:0]] : factory_byte(addr);
endmodule

// File: rtl/spd_busy_timer.sv
module spd_busy_timer #(
  parameter int WRITE_CYCLES = 1875000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (kick)        cnt <= CW'(WRITE_CYCLES);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/spd_i2c_target.sv
module spd_i2c_target
  import spd_pkg::*;
#(
  parameter int WRITE_CYCLES = 1875000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_pins,
  output logic       sda_oe
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev, busy, kick;
  spd_st_t st;
  logic [3:0] cnt;
  logic [7:0] sh, tx, rdata;
  logic [SPD_AW-1:0] ptr;
  logic rd_mode, wr_pend, oe_q;

  // named events for the checker
  logic rx_state, byte_done, store_we, in_dev_ack, in_idle, in_rack;
  assign rx_state   = (st == ST_DEV) || (st == ST_WADR) || (st == ST_WDAT);
  assign byte_done  = rx_state && scl_fall && (cnt == 4'd8);
  assign store_we   = (st == ST_WDAT) && byte_done;
  assign in_dev_ack = (st == ST_DEV_ACK);
  assign in_idle    = (st == ST_IDLE);
  assign in_rack    = (st == ST_RACK);
  assign kick       = stop_ev && wr_pend;

  spd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  spd_store u_store (
    .clk(clk), .rst_n(rst_n), .we(store_we), .addr(ptr), .wdata(sh), .rdata(rdata)
  );

  spd_busy_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      rd_mode <= 1'b0; wr_pend <= 1'b0; oe_q <= 1'b0;
    end else if (start_ev) begin
      st <= ST_DEV; cnt <= '0; oe_q <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE; cnt <= '0; oe_q <= 1'b0; wr_pend <= 1'b0;
    end else begin
      if (rx_state && scl_rise) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end
      unique case (st)
        ST_DEV: if (byte_done) begin
          cnt <= '0;
          if (dev_match(sh, addr_pins) && !busy) begin
            oe_q <= 1'b1; rd_mode <= sh[0]; st <= ST_DEV_ACK;
          end else st <= ST_IDLE;
        end
        ST_DEV_ACK: if (scl_fall) begin
          if (rd_mode) begin
            tx <= rdata; oe_q <= ~rdata[7]; cnt <= 4'd1; st <= ST_RDAT;
          end else begin
            oe_q <= 1'b0; st <= ST_WADR;
          end
        end
        ST_WADR: if (byte_done) begin
          cnt <= '0; ptr <= sh; oe_q <= 1'b1; st <= ST_WADR_ACK;
        end
        ST_WADR_ACK, ST_WDAT_ACK: if (scl_fall) begin
          oe_q <= 1'b0; st <= ST_WDAT;
        end
        ST_WDAT: if (byte_done) begin
          cnt <= '0; ptr <= next_ptr(ptr); wr_pend <= 1'b1;
          oe_q <= 1'b1; st <= ST_WDAT_ACK;
        end
        ST_RDAT: if (scl_fall) begin
          if (cnt == 4'd8) begin
            oe_q <= 1'b0; ptr <= next_ptr(ptr); cnt <= '0; st <= ST_RACK;
          end else begin
            oe_q <= ~tx[6]; tx <= {tx[6:0], 1'b0}; cnt <= cnt + 4'd1;
          end
        end
        ST_RACK: if (scl_rise) st <= sda_s ? ST_IDLE : ST_RLOAD;
        ST_RLOAD: if (scl_fall) begin
          tx <= rdata; oe_q <= ~rdata[7]; cnt <= 4'd1; st <= ST_RDAT;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/spd_i2c_chk.sv
module spd_i2c_chk
  import spd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_fall,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              busy,
  input logic              in_dev_ack,
  input logic              in_idle,
  input logic              in_rack,
  input logic              store_we,
  input logic [SPD_AW-1:0] ptr
);
  AST_OE_MOVES_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_ev) || $past(stop_ev))); // R1
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (in_idle && !sda_oe)); // R2
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe); // R2
  AST_HOST_ACK_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    in_rack |-> !sda_oe); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    store_we |=> (ptr == next_ptr($past(ptr)))); // R6
  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_dev_ack |-> !busy); // R9
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev)); // R9
endmodule

bind spd_i2c_target spd_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_ev(start_ev), .stop_ev(stop_ev), .busy(busy), .in_dev_ack(in_dev_ack),
  .in_idle(in_idle), .in_rack(in_rack), .store_we(store_we), .ptr(ptr)
);

// File: tb/spd_i2c_target_tb.sv
module spd_i2c_target_tb;
  localparam int WC = 2000;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_bus;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  spd_i2c_target #(.WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_pins(3'b000), .sda_oe(sda_oe)
  );

  // scoreboard
  int    exp_v[$];
  string exp_r[$];
  int    act_q[$];
  event  act_ev;

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic expect_item(string r, int v);
    exp_r.push_back(r);
    exp_v.push_back(v);
  endtask

  task automatic observe(int v);
    act_q.push_back(v);
    -> act_ev;
  endtask

  initial forever begin
    @(act_ev);
    while (act_q.size() > 0) begin
      int a;
      a = act_q.pop_front();
      if (exp_v.size() == 0) check("unexpected item", a, -1);
      else check(exp_r.pop_front(), a, exp_v.pop_front());
    end
  end

  function automatic int fac(int a);
    return ({a[3:0], a[7:4]} ^ 8'h5A);
  endfunction

  // host bit tasks
  task automatic waitq(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask
  task automatic bus_start;
    m_sda = 1'b1; waitq(); m_scl = 1'b1; waitq(); m_sda = 1'b0; waitq(); m_scl = 1'b0; waitq();
  endtask
  task automatic bus_stop;
    m_sda = 1'b0; waitq(); m_scl = 1'b1; waitq(); m_sda = 1'b1; waitq();
  endtask
  task automatic put_bit(logic b);
    m_sda = b; waitq(); m_scl = 1'b1; waitq(2); m_scl = 1'b0; waitq();
  endtask
  task automatic get_bit(output logic b);
    m_sda = 1'b1; waitq(); m_scl = 1'b1; waitq(); b = sda_bus; waitq(); m_scl = 1'b0; waitq();
  endtask
  task automatic put_byte(logic [7:0] v);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    observe(int'(a));
  endtask
  task automatic get_byte(logic host_ack);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    observe(int'(v));
    put_bit(host_ack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 reset releases line", int'(sda_oe), 0);

    // R2: no start -> address clocked in is not acknowledged
    expect_item("R2 no response before start", 1);
    put_byte(8'hA0);
    bus_stop();

    // R3 R4 R6 R8: write across wrap 0xFE,0xFF,0x00
    bus_start();
    expect_item("R3 address ack write", 0); put_byte(8'hA0);
    expect_item("R4 word address ack", 0);  put_byte(8'hFE);
    expect_item("R4 data ack FE", 0);       put_byte(8'h11);
    expect_item("R4 data ack FF", 0);       put_byte(8'h22);
    expect_item("R8 lower write acked", 0); put_byte(8'h33);
    bus_stop();

    // R9: busy right after stop
    bus_start();
    expect_item("R9 address refused while busy", 1); put_byte(8'hA0);
    bus_stop();
    repeat (WC + 50) @(negedge clk);

    // R11 R5 R7 R10 R6 R8: random read from 0xFD
    bus_start();
    expect_item("R9 address acked after interval", 0); put_byte(8'hA0);
    expect_item("R11 word address ack", 0);            put_byte(8'hFD);
    bus_start();
    expect_item("R3 address ack read", 0);             put_byte(8'hA1);
    expect_item("R10 upper reset value", 8'hFF);       get_byte(1'b0);
    expect_item("R7 readback FE", 8'h11);              get_byte(1'b0);
    expect_item("R7 readback FF", 8'h22);              get_byte(1'b0);
    expect_item("R8 factory byte 00 after wrap", fac(0)); get_byte(1'b1);
    get_bit(b);
    check("R5 line released after host nack", int'(b), 1);
    bus_stop();

    // R11: no busy after address-only write; pointer continues at 01
    bus_start();
    expect_item("R11 read acked without wait", 0); put_byte(8'hA1);
    expect_item("R6 pointer moved to 01", fac(1)); get_byte(1'b1);
    bus_stop();

    // R3: foreign addresses
    bus_start();
    expect_item("R3 pins mismatch nack", 1); put_byte(8'hA2);
    bus_stop();
    bus_start();
    expect_item("R3 prefix mismatch nack", 1); put_byte(8'hB0);
    bus_stop();
    check("R2 idle after stop", int'(sda_oe), 0);

    // R7: write 0x80 then read back
    bus_start();
    expect_item("R3 ack", 0);        put_byte(8'hA0);
    expect_item("R4 addr ack", 0);   put_byte(8'h80);
    expect_item("R4 data ack", 0);   put_byte(8'h5C);
    bus_stop();
    repeat (WC + 50) @(negedge clk);
    bus_start();
    expect_item("R3 ack", 0);        put_byte(8'hA0);
    expect_item("R11 addr ack", 0);  put_byte(8'h80);
    bus_start();
    expect_item("R3 ack read", 0);   put_byte(8'hA1);
    expect_item("R7 readback 80", 8'h5C); get_byte(1'b1);
    bus_stop();

    repeat (20) @(negedge clk);
    check("R5 scoreboard drained", exp_v.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule